// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates the interrupt requests of a small 8-bit microcontroller core. Ten sources feed it. Six are level flags whose owners clear them: external lines 0, 1 and 2, timers 0 and 1, and the watchdog. The serial port and the divider each send a set pulse, and the controller holds the resulting flag. The analog comparator sends its live result, and the controller flags each rising edge. A caller-ID group sends five sub-flags, which the controller holds and ORs into one request. A register write port sets a global enable, a per-source enable and a per-source priority level. The priority level is high or low.

At each instruction boundary the controller looks at the eligible requests, provided no request is already outstanding. It takes the winner and raises a request to the CPU with a fixed vector address. The vector stays stable until the CPU acknowledges it. The acknowledge marks the winner's level as in service and clears the flags that the controller owns for that source. A return strobe retires the highest level in service. A low-level request is accepted only when nothing is in service. A high-level request is accepted only when no high-level service is in progress.

Top module: `irq_vic`

## Requirements
- R1: After reset, `irq_req`, `irq_vec`, `irq_active` and `pend_flags` are all zero, and every enable and priority bit is cleared.
- R2: Bit 7 of the register at address 0 is the global enable. While it is 0, no request is raised, whatever the per-source enables say.
- R3: Per-source enables are at address 0 and address 1. At address 0: bit 0 is external 0, bit 1 is timer 0, bit 2 is external 1, bit 3 is timer 1 and bit 6 is serial. At address 1: bit 0 is external 2, bit 1 is the divider, bit 2 is the comparator, bit 3 is caller-ID and bit 5 is the watchdog. A disabled source never wins.
- R4: Priority bits use the same bit positions at address 2 (in place of address 0) and address 3 (in place of address 1). A value of 1 means high. An eligible high request always beats an eligible low request.
- R5: Among eligible requests at the same level, the lowest rank wins. Rank and `pend_flags` bit order are the same: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 external 2, 6 watchdog, 7 divider, 8 comparator, 9 caller-ID.
- R6: The vectors for ranks 0 to 9 are 03h, 0Bh, 13h, 1Bh, 3Bh, 43h, 4Bh, 53h, 5Bh and 63h.
- R7: Arbitration takes place only on a cycle with `insn_bnd` high and no request outstanding. The result appears on `irq_req`/`irq_vec` in the next cycle. From then until `irq_ack`, both `irq_req` and `irq_vec` hold steady.
- R8: An acknowledge sets the in-service bit of the taken level (`irq_active` bit 1 high, bit 0 low). A low request is accepted only while `irq_active` is 0. A high request is accepted only while `irq_active[1]` is 0.
- R9: An `irq_reti` pulse clears the highest set bit of `irq_active`.
- R10: The serial and divider flags (`pend_flags` bits 4 and 7) are set by their pulse inputs. They are cleared when their own request is acknowledged. If a set pulse arrives in the acknowledge cycle, the set wins.
- R11: The comparator flag (`pend_flags` bit 8) is set only by a 0-to-1 change of `cmp_level`. A level that stays high does not set it again. It is cleared when its own request is acknowledged.
- R12: `pend_flags` bit 9 is the OR of five caller-ID sub-flags. Each sub-flag is set by its `cid_set` bit and cleared only by its `cid_clr` bit. An acknowledge does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0/1 enables, 2/3 priorities |
| cfg_wdata | input | 8 | Write data |
| ext0_flag | input | 1 | External line 0 request level |
| tmr0_flag | input | 1 | Timer 0 overflow level |
| ext1_flag | input | 1 | External line 1 request level |
| tmr1_flag | input | 1 | Timer 1 overflow level |
| ext2_flag | input | 1 | External line 2 request level |
| wdt_flag | input | 1 | Watchdog time-out level |
| ser_set | input | 1 | Serial event pulse |
| div_set | input | 1 | Divider overflow pulse |
| cmp_level | input | 1 | Live comparator result |
| cid_set | input | 5 | Caller-ID sub-flag set pulses |
| cid_clr | input | 5 | Caller-ID sub-flag software clears |
| insn_bnd | input | 1 | Instruction boundary strobe |
| irq_ack | input | 1 | CPU acknowledge of the outstanding request |
| irq_reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 8 | Vector address of the request |
| irq_active | output | 2 | In-service bits (1 high, 0 low) |
| pend_flags | output | 10 | Pending request flags in rank order |

## Verification
The assertions assume three things about the CPU side. `irq_ack` is driven only while `irq_req` is high. `irq_reti` is driven only when a level is in service. The two never arrive in the same cycle. The bench keeps to this through its helper tasks, which issue an acknowledge only after a request has been seen and a return only after a matching acknowledge. Changes to source inputs, configuration writes and boundary strobes are all applied on the falling edge. The bench may change them while a request is outstanding, because the design has to tolerate that.

// File: rtl/irq_vic_pkg.sv
package irq_vic_pkg;
  localparam int NSRC  = 10;
  localparam int IDXW  = $clog2(NSRC);
  localparam int CID_N = 5;
  localparam int LVLS  = 2;

  localparam int I_SER = 4;
  localparam int I_DIV = 7;
  localparam int I_CMP = 8;

  // Vector address for a rank: ranks 0..3 sit in slots 0..3, the rest skip three slots.
  function automatic logic [7:0] vec_of(input logic [IDXW-1:0] idx);
    logic [7:0] slot;
    slot = (idx < IDXW'(4)) ? 8'(idx) : 8'(idx) + 8'd3;
    return {slot[4:0], 3'b011};
  endfunction

  // Gather per-source bits from the two 8-bit registers into rank order.
  function automatic logic [NSRC-1:0] map_bits(input logic [7:0] ra, input logic [7:0] rb);
    return {rb[3], rb[2], rb[1], rb[5], rb[0], ra[6], ra[3], ra[2], ra[1], ra[0]};
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_vic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [1:0]      addr,
  input  logic [7:0]      wdata,
  output logic            glb_en,
  output logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] src_hi
);
  logic [7:0] en_a, en_b, pri_a, pri_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a  <= '0;
      en_b  <= '0;
      pri_a <= '0;
      pri_b <= '0;
    end else if (we) begin
      case (addr)
        2'd0:    en_a  <= wdata;
        2'd1:    en_b  <= wdata;
        2'd2:    pri_a <= wdata;
        default: pri_b <= wdata;
      endcase
    end
  end

  assign glb_en = en_a[7];
  assign src_en = map_bits(en_a, en_b);
  assign src_hi = map_bits(pri_a, pri_b);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_vic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext0_flag,
  input  logic             tmr0_flag,
  input  logic             ext1_flag,
  input  logic             tmr1_flag,
  input  logic             ext2_flag,
  input  logic             wdt_flag,
  input  logic             ser_set,
  input  logic             div_set,
  input  logic             cmp_level,
  input  logic [CID_N-1:0] cid_set,
  input  logic [CID_N-1:0] cid_clr,
  input  logic             ack_ser,
  input  logic             ack_div,
  input  logic             ack_cmp,
  output logic             cmp_rise,
  output logic [NSRC-1:0]  pend
);
  logic             ser_q, div_q, cmp_q, cmp_prev;
  logic [CID_N-1:0] cid_q;

  assign cmp_rise = cmp_level & ~cmp_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q    <= 1'b0;
      div_q    <= 1'b0;
      cmp_q    <= 1'b0;
      cmp_prev <= 1'b0;
    end else begin
      ser_q    <= ser_set  | (ser_q & ~ack_ser);
      div_q    <= div_set  | (div_q & ~ack_div);
      cmp_q    <= cmp_rise | (cmp_q & ~ack_cmp);
      cmp_prev <= cmp_level;
    end
  end

  for (genvar g = 0; g < CID_N; g++) begin : g_cid
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cid_q[g] <= 1'b0;
      else        cid_q[g] <= cid_set[g] | (cid_q[g] & ~cid_clr[g]);
    end
  end

  assign pend = {|cid_q, cmp_q, div_q, wdt_flag, ext2_flag, ser_q,
                 tmr1_flag, ext1_flag, tmr0_flag, ext0_flag};
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_vic_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_hi,
  input  logic            glb_en,
  input  logic [LVLS-1:0] isr,
  output logic            found,
  output logic            lvl,
  output logic [NSRC-1:0] grant,
  output logic [IDXW-1:0] idx
);
  logic [NSRC-1:0] live, hi_c, lo_c, cand;

  assign live = pend & src_en & {NSRC{glb_en}};
  assign hi_c = live &  src_hi & {NSRC{~isr[1]}};
  assign lo_c = live & ~src_hi & {NSRC{isr == '0}};
  assign lvl  = |hi_c;
  assign cand = lvl ? hi_c : lo_c;
  assign found = |cand;

  always_comb begin
    grant = '0;
    idx   = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (cand[k]) begin
        grant = NSRC'(1) << k;
        idx   = IDXW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track
  import irq_vic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            take_lvl,
  input  logic            reti,
  output logic [LVLS-1:0] isr
);
  logic [LVLS-1:0] drop, add;

  assign drop = !reti ? 2'b00 : (isr[1] ? 2'b10 : (isr[0] ? 2'b01 : 2'b00));
  assign add  = !take ? 2'b00 : (take_lvl ? 2'b10 : 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~drop) | add;
  end
endmodule

// File: rtl/irq_vic.sv
module irq_vic
  import irq_vic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic             ext0_flag,
  input  logic             tmr0_flag,
  input  logic             ext1_flag,
  input  logic             tmr1_flag,
  input  logic             ext2_flag,
  input  logic             wdt_flag,
  input  logic             ser_set,
  input  logic             div_set,
  input  logic             cmp_level,
  input  logic [CID_N-1:0] cid_set,
  input  logic [CID_N-1:0] cid_clr,
  input  logic             insn_bnd,
  input  logic             irq_ack,
  input  logic             irq_reti,
  output logic             irq_req,
  output logic [7:0]       irq_vec,
  output logic [LVLS-1:0]  irq_active,
  output logic [NSRC-1:0]  pend_flags
);
  logic            glb_en;
  logic [NSRC-1:0] src_en, src_hi, grant;
  logic            found, lvl, cmp_rise;
  logic [IDXW-1:0] idx;
  logic [LVLS-1:0] isr;

  logic            req_q, lvl_q;
  logic [7:0]      vec_q;
  logic [IDXW-1:0] idx_q;

  logic sample, take;
  assign sample = insn_bnd & ~req_q & found;
  assign take   = irq_ack & req_q;

  irq_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .glb_en(glb_en), .src_en(src_en), .src_hi(src_hi)
  );

  irq_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n),
    .ext0_flag(ext0_flag), .tmr0_flag(tmr0_flag), .ext1_flag(ext1_flag),
    .tmr1_flag(tmr1_flag), .ext2_flag(ext2_flag), .wdt_flag(wdt_flag),
    .ser_set(ser_set), .div_set(div_set), .cmp_level(cmp_level),
    .cid_set(cid_set), .cid_clr(cid_clr),
    .ack_ser(take && idx_q == IDXW'(I_SER)),
    .ack_div(take && idx_q == IDXW'(I_DIV)),
    .ack_cmp(take && idx_q == IDXW'(I_CMP)),
    .cmp_rise(cmp_rise), .pend(pend_flags)
  );

  irq_pick u_pick (
    .pend(pend_flags), .src_en(src_en), .src_hi(src_hi), .glb_en(glb_en), .isr(isr),
    .found(found), .lvl(lvl), .grant(grant), .idx(idx)
  );

  irq_isr_track u_isr (
    .clk(clk), .rst_n(rst_n), .take(take), .take_lvl(lvl_q), .reti(irq_reti), .isr(isr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lvl_q <= 1'b0;
      vec_q <= '0;
      idx_q <= '0;
    end else if (sample) begin
      req_q <= 1'b1;
      lvl_q <= lvl;
      vec_q <= vec_of(idx);
      idx_q <= idx;
    end else if (take) begin
      req_q <= 1'b0;
    end
  end

  assign irq_req    = req_q;
  assign irq_vec    = vec_q;
  assign irq_active = isr;
endmodule

// File: rtl/irq_vic_chk.sv
module irq_vic_chk
  import irq_vic_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic [7:0]       irq_vec,
  input logic             irq_ack,
  input logic             irq_reti,
  input logic             insn_bnd,
  input logic             ser_set,
  input logic [CID_N-1:0] cid_clr,
  input logic [NSRC-1:0]  pend_flags,
  input logic [LVLS-1:0]  isr,
  input logic             glb_en,
  input logic [NSRC-1:0]  grant,
  input logic             cmp_rise,
  input logic             lvl_q,
  input logic [IDXW-1:0]  idx_q,
  input logic             take
);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

  a_r7_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(insn_bnd));

  a_r2_global: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(glb_en));

  a_r8_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) && !lvl_q |-> $past(isr) == 2'b00);

  a_r8_high_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) && lvl_q |-> !$past(isr[1]));

  a_r9_reti_high: assert property (@(posedge clk) disable iff (!rst_n)
    isr[1] && irq_reti && !take |=> !isr[1]);

  a_r10_ser_clear: assert property (@(posedge clk) disable iff (!rst_n)
    take && idx_q == IDXW'(I_SER) && !ser_set |=> !pend_flags[I_SER]);

  a_r11_cmp_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_rise |=> !$rose(pend_flags[I_CMP]));

  a_r12_cid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pend_flags[NSRC-1] && cid_clr == '0 |=> pend_flags[NSRC-1]);

  a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~pend_flags) == '0));
endmodule

bind irq_vic irq_vic_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack),
  .irq_reti(irq_reti), .insn_bnd(insn_bnd), .ser_set(ser_set), .cid_clr(cid_clr),
  .pend_flags(pend_flags), .isr(isr), .glb_en(glb_en), .grant(grant),
  .cmp_rise(cmp_rise), .lvl_q(lvl_q), .idx_q(idx_q), .take(take)
);

// File: tb/irq_vic_tb.sv
`timescale 1ns/1ps
module irq_vic_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic e0, t0, e1, t1, e2, wd, ser_set, div_set, cmp_level;
  logic [4:0] cid_set, cid_clr;
  logic insn_bnd, irq_ack, irq_reti;
  logic       irq_req;
  logic [7:0] irq_vec;
  logic [1:0] irq_active;
  logic [9:0] pend_flags;

  int checks = 0, fails = 0;
  bit done = 0;

  irq_vic u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ext0_flag(e0), .tmr0_flag(t0), .ext1_flag(e1), .tmr1_flag(t1), .ext2_flag(e2),
    .wdt_flag(wd), .ser_set(ser_set), .div_set(div_set), .cmp_level(cmp_level),
    .cid_set(cid_set), .cid_clr(cid_clr), .insn_bnd(insn_bnd), .irq_ack(irq_ack),
    .irq_reti(irq_reti), .irq_req(irq_req), .irq_vec(irq_vec), .irq_active(irq_active),
    .pend_flags(pend_flags)
  );

  function automatic int exp_vec(input int k);
    return (k < 4) ? 3 + 8 * k : 59 + 8 * (k - 4);
  endfunction

  function automatic logic [15:0] regs_of(input logic [9:0] m);
    logic [7:0] a, b;
    a = '0; b = '0;
    a[0] = m[0]; a[1] = m[1]; a[2] = m[2]; a[3] = m[3]; a[6] = m[4];
    b[0] = m[5]; b[5] = m[6]; b[1] = m[7]; b[2] = m[8]; b[3] = m[9];
    return {b, a};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; tick(); cfg_we = 0;
  endtask

  task automatic set_enables(input logic [9:0] m, input bit glob);
    logic [15:0] r;
    r = regs_of(m);
    cfg_wr(2'd0, {glob, r[6:0]});
    cfg_wr(2'd1, r[15:8]);
  endtask

  task automatic set_prio(input logic [9:0] m);
    logic [15:0] r;
    r = regs_of(m);
    cfg_wr(2'd2, r[7:0]);
    cfg_wr(2'd3, r[15:8]);
  endtask

  task automatic set_src(input int k, input logic v, input int sub);
    case (k)
      0: e0 = v;  1: t0 = v;  2: e1 = v;  3: t1 = v;
      4: ser_set = v;  5: e2 = v;  6: wd = v;  7: div_set = v;
      8: cmp_level = v;
      default: cid_set[sub] = v;
    endcase
  endtask

  task automatic end_pulses(); ser_set = 0; div_set = 0; cid_set = '0; endtask

  task automatic drop_one(input int k);
    case (k)
      0: e0 = 0;  1: t0 = 0;  2: e1 = 0;  3: t1 = 0;  5: e2 = 0;  6: wd = 0;
      8: cmp_level = 0;
      9: cid_clr = '1;
      default: ;
    endcase
    tick(); cid_clr = '0;
  endtask

  task automatic drop_all();
    e0 = 0; t0 = 0; e1 = 0; t1 = 0; e2 = 0; wd = 0; cmp_level = 0; cid_clr = '1;
    tick(); cid_clr = '0;
  endtask

  task automatic raise_all();
    for (int k = 0; k < 10; k++) set_src(k, 1'b1, 0);
    tick(); end_pulses();
  endtask

  task automatic bnd();  insn_bnd = 1; tick(); insn_bnd = 0; endtask
  task automatic ack();  irq_ack  = 1; tick(); irq_ack  = 0; endtask
  task automatic reti(); irq_reti = 1; tick(); irq_reti = 0; endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    e0 = 0; t0 = 0; e1 = 0; t1 = 0; e2 = 0; wd = 0;
    ser_set = 0; div_set = 0; cmp_level = 0; cid_set = 0; cid_clr = 0;
    insn_bnd = 0; irq_ack = 0; irq_reti = 0;
    repeat (3) tick();
    rst_n = 1; tick();

    // R1 reset state
    chk("R1 req", irq_req, 0);
    chk("R1 vec", irq_vec, 0);
    chk("R1 active", irq_active, 0);
    chk("R1 pend", pend_flags, 0);
    e0 = 1; tick(); bnd();
    chk("R1 enables cleared, no request", irq_req, 0);
    e0 = 0; tick();

    // R2 global enable
    set_enables('1, 1'b0);
    e0 = 1; tick(); bnd();
    chk("R2 global off blocks", irq_req, 0);
    set_enables('1, 1'b1);
    bnd();
    chk("R2 global on req", irq_req, 1);
    chk("R2 global on vec", irq_vec, 3);
    ack(); e0 = 0; reti();

    // R4 R5 R6 R8 R9 pair sweep
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 10; j++) begin
        if (i != j) begin
          for (int p = 0; p < 4; p++) begin
            logic [9:0] m;
            int first, second, sub;
            bit hf;
            m = '0; m[i] = p[0]; m[j] = p[1];
            set_prio(m);
            if (p[0] != p[1]) first = p[0] ? i : j;
            else first = (i < j) ? i : j;
            second = (first == i) ? j : i;
            hf = m[first];
            sub = (i + j + p) % 5;
            set_src(i, 1'b1, sub); set_src(j, 1'b1, sub);
            tick(); end_pulses();
            bnd();
            chk("R5 first req", irq_req, 1);
            chk("R4/R5/R6 first vec", irq_vec, exp_vec(first));
            ack();
            chk("R8 active after ack", irq_active, hf ? 2 : 1);
            drop_one(first);
            bnd();
            chk("R8 loser blocked", irq_req, 0);
            reti();
            chk("R9 active cleared", irq_active, 0);
            bnd();
            chk("R6 second req", irq_req, 1);
            chk("R6 second vec", irq_vec, exp_vec(second));
            ack(); drop_one(second); reti();
            chk("R10/R11/R12 pend clean", pend_flags, 0);
          end
        end
      end
    end
    set_prio('0);

    // R3 per-source enable: all raised, only one enabled
    drop_all();
    for (int k = 0; k < 10; k++) begin
      set_enables(10'(1) << k, 1'b1);
      raise_all();
      bnd();
      chk("R3 single enable vec", irq_vec, exp_vec(k));
      ack(); reti();
    end
    set_enables('1, 1'b1);
    drop_all();
    raise_all();
    for (int k = 0; k < 10; k++) begin
      bnd();
      chk("R5 chain vec", irq_vec, exp_vec(k));
      ack(); drop_one(k); reti();
    end
    chk("R5 chain pend clean", pend_flags, 0);

    // R7 boundary and hold
    e1 = 1; repeat (3) tick();
    chk("R7 no boundary no req", irq_req, 0);
    bnd();
    chk("R7 vec", irq_vec, 8'h13);
    cfg_wr(2'd2, 8'h01);
    e0 = 1; bnd(); bnd();
    chk("R7 held req", irq_req, 1);
    chk("R7 held vec", irq_vec, 8'h13);
    ack();
    chk("R7 req drops on ack", irq_req, 0);
    bnd();
    chk("R8 high preempts low", irq_vec, 8'h03);
    ack();
    chk("R8 both levels active", irq_active, 3);
    e0 = 0; reti(); reti(); e1 = 0; cfg_wr(2'd2, 8'h00);
    chk("R9 all retired", irq_active, 0);

    // R8 R9 nesting
    cfg_wr(2'd2, 8'h0A);
    e0 = 1; bnd();
    chk("R8 low taken", irq_vec, 8'h03);
    ack(); e0 = 0;
    chk("R8 low in service", irq_active, 1);
    t0 = 1; bnd();
    chk("R8 high over low", irq_vec, 8'h0B);
    ack(); t0 = 0;
    chk("R8 both in service", irq_active, 3);
    e1 = 1; t1 = 1; tick(); bnd();
    chk("R8 high-in-service blocks all", irq_req, 0);
    reti();
    chk("R9 highest cleared", irq_active, 1);
    bnd();
    chk("R8 high after reti", irq_vec, 8'h1B);
    ack(); t1 = 0;
    reti();
    chk("R9 back to low", irq_active, 1);
    bnd();
    chk("R8 low blocked by low", irq_req, 0);
    reti();
    chk("R9 idle", irq_active, 0);
    bnd();
    chk("R8 low resumes", irq_vec, 8'h13);
    ack(); e1 = 0; reti();
    cfg_wr(2'd2, 8'h00);

    // R10 auto clear and set priority
    ser_set = 1; tick(); ser_set = 0;
    chk("R10 serial set", pend_flags[4], 1);
    bnd();
    chk("R10 serial vec", irq_vec, 8'h3B);
    irq_ack = 1; ser_set = 1; tick(); irq_ack = 0; ser_set = 0;
    chk("R10 set wins over ack", pend_flags[4], 1);
    reti(); bnd(); ack();
    chk("R10 serial cleared by ack", pend_flags[4], 0);
    reti();
    div_set = 1; tick(); div_set = 0;
    chk("R10 divider set", pend_flags[7], 1);
    bnd(); ack();
    chk("R10 divider cleared by ack", pend_flags[7], 0);
    reti();

    // R11 comparator edge
    cmp_level = 1; tick();
    chk("R11 rise sets", pend_flags[8], 1);
    bnd();
    chk("R11 vec", irq_vec, 8'h5B);
    ack();
    chk("R11 cleared by ack", pend_flags[8], 0);
    reti(); repeat (4) tick();
    chk("R11 steady high no set", pend_flags[8], 0);
    bnd();
    chk("R11 steady high no req", irq_req, 0);
    cmp_level = 0; tick(); cmp_level = 1; tick();
    chk("R11 second rise sets", pend_flags[8], 1);
    bnd(); ack(); reti(); cmp_level = 0; tick();

    // R12 caller-ID group
    for (int s = 0; s < 5; s++) begin
      cid_set = 5'(1) << s; tick(); cid_set = 0;
      chk("R12 sub sets", pend_flags[9], 1);
      cid_clr = 5'(1) << s; tick(); cid_clr = 0;
      chk("R12 sub clears", pend_flags[9], 0);
    end
    cid_set = 5'b01010; tick(); cid_set = 0;
    bnd();
    chk("R12 vec", irq_vec, 8'h63);
    ack();
    chk("R12 ack leaves flag", pend_flags[9], 1);
    reti();
    cid_clr = 5'b00010; tick(); cid_clr = 0;
    chk("R12 one sub left", pend_flags[9], 1);
    cid_clr = 5'b01000; tick(); cid_clr = 0;
    chk("R12 all clear", pend_flags[9], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule